// File: doc/BRIEF.md
# Road Combination Linear Track Fitter

The block takes one matched road at a time: a packet of up to four signed hit coordinates for each detector layer, plus a hit count per layer. It walks through every combination that uses exactly one hit from each layer. For every combination it computes a row of fixed-point dot products between the coordinate vector and a coefficient matrix held in local storage. Some rows give track parameters and the remaining rows give fit constraints. The sum of the squared constraint values is a quality figure, and a combination leaves the block as a candidate only when that figure is no greater than a programmable cut.

The coefficient storage holds one matrix for a road with every layer populated, plus one matrix for each layer that may be missing. This lets a single datapath fit roads that have one empty layer. While a road is being enumerated the road input is held off. A new road is taken in only after the last combination of the current road has been issued. Candidates come out as a stream with a fixed pipeline delay.

Top module: `road_track_fitter`

## Requirements
- R1: After reset `road_ready_o` is 1 and `cand_valid_o` is 0. From the cycle after a road is accepted, `road_ready_o` stays 0 for exactly as many cycles as the road has combinations, then returns to 1.
- R2: Combinations are issued one per cycle in odometer order, with the hit index of the highest-numbered layer changing fastest. `cand_hit_o` carries the hit index of layer l in bits [2l+1:2l].
- R3: Track parameter p (rows 0 and 1) equals the row's offset plus the sum over layers of coefficient times coordinate, in 40-bit two's complement. Parameter p is placed at `cand_par_o[40p+39:40p]`.
- R4: The quality figure is the sum of the squares of the constraint rows (rows 2 and 3), each taken as a 40-bit signed value. It saturates to 2^40-1 when it does not fit in 40 bits.
- R5: A combination produces a candidate exactly when its quality figure is no greater than `cut_i`, compared as unsigned. Rejected combinations produce no output cycle.
- R6: If exactly one layer has a hit count of 0, coefficient set number equal to that layer is used. That layer's coordinate counts as zero and its index field is 0. A road with all layers populated uses set 4.
- R7: A road with two or more empty layers is consumed without producing candidates, and `road_ready_o` stays 1.
- R8: A hit count above 4 is treated as 4.
- R9: A coefficient write stores `coef_data_i` at the given set, row (0 and 1 for parameters, 2 and 3 for constraints) and column. Columns 0 to 3 hold the layer weights and column 4 holds the row offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_set_i | input | 3 | Coefficient set address |
| coef_row_i | input | 2 | Coefficient row address |
| coef_col_i | input | 3 | Coefficient column address |
| coef_data_i | input | 16 | Signed coefficient value |
| cut_i | input | 40 | Quality cut, unsigned |
| road_valid_i | input | 1 | Road packet present |
| road_ready_o | output | 1 | Fitter idle and able to take a road |
| road_hits_i | input | 256 | Coordinates, hit h of layer l at bits [(4l+h)*16 +: 16] |
| road_cnt_i | input | 12 | Hit count of layer l at bits [3l+2:3l] |
| cand_valid_o | output | 1 | Candidate present |
| cand_par_o | output | 80 | Two signed track parameters |
| cand_chi_o | output | 40 | Quality figure of the candidate |
| cand_hit_o | output | 8 | Hit index used in each layer |

## Verification
A fault in the odometer shows up in the first road it touches. It either changes how long `road_ready_o` stays low, or it drops, repeats or reorders candidates in a stream whose order is fully predictable. A wrong coefficient set selection or a wrongly zeroed missing coordinate changes the parameters of the very first candidate of that road, two cycles after acceptance. Faults in squaring, saturation or the cut comparison show as wrong quality values or as candidates that appear or vanish. The saturation and all-pass cases are driven on purpose so that these faults are exercised.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/fit_coef_store.sv
module fit_coef_store #(
  parameter int N_LAYERS = 4,
  parameter int N_ROWS   = 4,
  parameter int KW       = 16,
  parameter int N_SETS   = N_LAYERS + 1,
  parameter int N_COLS   = N_LAYERS + 1,
  parameter int SW       = $clog2(N_SETS),
  parameter int RW       = $clog2(N_ROWS),
  parameter int CLW      = $clog2(N_COLS)
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    we_i,
  input  logic [SW-1:0]                           wset_i,
  input  logic [RW-1:0]                           wrow_i,
  input  logic [CLW-1:0]                          wcol_i,
  input  logic [KW-1:0]                           wdata_i,
  input  logic [SW-1:0]                           rset_i,
  output logic [N_ROWS-1:0][N_COLS-1:0][KW-1:0]   rcoef_o
);
  logic [N_SETS-1:0][N_ROWS-1:0][N_COLS-1:0][KW-1:0] mem_q;
  logic wr_ok;

  assign wr_ok = we_i && (32'(wset_i) < N_SETS) && (32'(wrow_i) < N_ROWS) &&
                 (32'(wcol_i) < N_COLS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_ok) mem_q[wset_i][wrow_i][wcol_i] <= wdata_i;
  end

  assign rcoef_o = mem_q[rset_i];
endmodule

// File: rtl/fit_comb_seq.sv
module fit_comb_seq
  import fit_pkg::*;
#(
  parameter int N_LAYERS = 4,
  parameter int MAX_HITS = 4,
  parameter int CW       = 16,
  parameter int CNTW     = $clog2(MAX_HITS + 1),
  parameter int IDXW     = $clog2(MAX_HITS > 1 ? MAX_HITS : 2),
  parameter int SW       = $clog2(N_LAYERS + 1)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   road_valid_i,
  output logic                                   road_ready_o,
  input  logic [N_LAYERS-1:0][MAX_HITS-1:0][CW-1:0] road_hits_i,
  input  logic [N_LAYERS-1:0][CNTW-1:0]          road_cnt_i,
  output logic                                   comb_valid_o,
  output logic [N_LAYERS-1:0][CW-1:0]            comb_x_o,
  output logic [N_LAYERS-1:0][IDXW-1:0]          comb_idx_o,
  output logic [SW-1:0]                          comb_set_o
);
  seq_state_e state_q;
  logic [N_LAYERS-1:0][MAX_HITS-1:0][CW-1:0] hits_q;
  logic [N_LAYERS-1:0][CNTW-1:0] lim_q, cnt_cl;
  logic [N_LAYERS-1:0][IDXW-1:0] idx_q, idx_nxt;
  logic [N_LAYERS-1:0] miss_q, empty;
  logic [SW-1:0] set_q, set_in;
  logic skip, wrap, accept;
  int n_empty;

  assign road_ready_o = (state_q == SEQ_IDLE);
  assign accept       = road_valid_i && road_ready_o;

  // clamp counts, locate empty layers
  always_comb begin
    n_empty = 0;
    set_in  = SW'(N_LAYERS);
    for (int l = 0; l < N_LAYERS; l++) begin
      cnt_cl[l] = (road_cnt_i[l] > CNTW'(MAX_HITS)) ? CNTW'(MAX_HITS) : road_cnt_i[l];
      empty[l]  = (cnt_cl[l] == '0);
      if (empty[l]) begin
        n_empty = n_empty + 1;
        set_in  = SW'(l);
      end
    end
    skip = (n_empty > 1);
  end

  // odometer, last layer fastest; wrap=1 marks the final combination
  always_comb begin
    wrap    = 1'b1;
    idx_nxt = idx_q;
    for (int l = N_LAYERS - 1; l >= 0; l--) begin
      if (wrap) begin
        if (CNTW'(idx_q[l]) + CNTW'(1) == lim_q[l]) idx_nxt[l] = '0;
        else begin
          idx_nxt[l] = idx_q[l] + IDXW'(1);
          wrap       = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      hits_q  <= '0;
      lim_q   <= '0;
      miss_q  <= '0;
      set_q   <= '0;
      idx_q   <= '0;
    end else if (accept) begin
      hits_q <= road_hits_i;
      for (int l = 0; l < N_LAYERS; l++) lim_q[l] <= empty[l] ? CNTW'(1) : cnt_cl[l];
      miss_q  <= empty;
      set_q   <= set_in;
      idx_q   <= '0;
      state_q <= skip ? SEQ_IDLE : SEQ_RUN;
    end else if (state_q == SEQ_RUN) begin
      idx_q <= idx_nxt;
      if (wrap) state_q <= SEQ_IDLE;
    end
  end

  assign comb_valid_o = (state_q == SEQ_RUN);
  assign comb_idx_o   = idx_q;
  assign comb_set_o   = set_q;
  always_comb begin
    for (int l = 0; l < N_LAYERS; l++)
      comb_x_o[l] = miss_q[l] ? '0 : hits_q[l][idx_q[l]];
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !skip) |=> !road_ready_o);
  // R2
  odo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_valid_o && $past(comb_valid_o)) |-> (idx_q != $past(idx_q)));
  for (genvar g = 0; g < N_LAYERS; g++) begin : g_rng
    // R2
    idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      comb_valid_o |-> (CNTW'(idx_q[g]) < lim_q[g]));
  end
endmodule

// File: rtl/fit_dot_stage.sv
module fit_dot_stage #(
  parameter int N_LAYERS = 4,
  parameter int N_ROWS   = 4,
  parameter int CW       = 16,
  parameter int KW       = 16,
  parameter int AW       = 40,
  parameter int IDXW     = 2,
  parameter int N_COLS   = N_LAYERS + 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  valid_i,
  input  logic [N_LAYERS-1:0][CW-1:0]           x_i,
  input  logic [N_LAYERS-1:0][IDXW-1:0]         idx_i,
  input  logic [N_ROWS-1:0][N_COLS-1:0][KW-1:0] coef_i,
  output logic                                  valid_o,
  output logic [N_ROWS-1:0][AW-1:0]             row_o,
  output logic [N_LAYERS-1:0][IDXW-1:0]         idx_o
);
  localparam int PW = CW + KW;

  logic [N_ROWS-1:0][AW-1:0] row_d;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    always_comb begin
      logic [AW-1:0] acc;
      logic signed [PW-1:0] prod;
      acc = {{(AW - KW){coef_i[r][N_LAYERS][KW-1]}}, coef_i[r][N_LAYERS]};
      for (int l = 0; l < N_LAYERS; l++) begin
        prod = $signed(coef_i[r][l]) * $signed(x_i[l]);
        acc  = acc + {{(AW - PW){prod[PW-1]}}, prod};
      end
      row_d[r] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      row_o   <= '0;
      idx_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        row_o <= row_d;
        idx_o <= idx_i;
      end
    end
  end
endmodule

// File: rtl/fit_quality.sv
module fit_quality #(
  parameter int N_PAR    = 2,
  parameter int N_CON    = 2,
  parameter int AW       = 40,
  parameter int N_LAYERS = 4,
  parameter int IDXW     = 2,
  parameter int N_ROWS   = N_PAR + N_CON
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [N_ROWS-1:0][AW-1:0]     row_i,
  input  logic [N_LAYERS-1:0][IDXW-1:0] idx_i,
  input  logic [AW-1:0]                 cut_i,
  output logic                          cand_valid_o,
  output logic [N_PAR-1:0][AW-1:0]      cand_par_o,
  output logic [AW-1:0]                 cand_chi_o,
  output logic [N_LAYERS-1:0][IDXW-1:0] cand_idx_o
);
  localparam int SQW = 2 * AW + $clog2(N_CON) + 1;

  logic [SQW-1:0] sum_sq;
  logic [AW-1:0]  chi_d;
  logic           pass;

  always_comb begin
    logic signed [2*AW-1:0] sq;
    sum_sq = '0;
    for (int c = 0; c < N_CON; c++) begin
      sq     = $signed(row_i[N_PAR + c]) * $signed(row_i[N_PAR + c]);
      sum_sq = sum_sq + SQW'($unsigned(sq));
    end
    chi_d = (|sum_sq[SQW-1:AW]) ? '1 : sum_sq[AW-1:0];
    pass  = (chi_d <= cut_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_valid_o <= 1'b0;
      cand_par_o   <= '0;
      cand_chi_o   <= '0;
      cand_idx_o   <= '0;
    end else begin
      cand_valid_o <= valid_i && pass;
      if (valid_i) begin
        cand_par_o <= row_i[N_PAR-1:0];
        cand_chi_o <= chi_d;
        cand_idx_o <= idx_i;
      end
    end
  end

  // R5
  cut_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_chi_o <= $past(cut_i)));
endmodule

// File: rtl/road_track_fitter.sv
module road_track_fitter #(
  parameter int N_LAYERS = 4,
  parameter int MAX_HITS = 4,
  parameter int N_PAR    = 2,
  parameter int N_CON    = 2,
  parameter int CW       = 16,
  parameter int KW       = 16,
  parameter int AW       = 40
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         coef_we_i,
  input  logic [$clog2(N_LAYERS+1)-1:0]                coef_set_i,
  input  logic [$clog2(N_PAR+N_CON)-1:0]               coef_row_i,
  input  logic [$clog2(N_LAYERS+1)-1:0]                coef_col_i,
  input  logic [KW-1:0]                                coef_data_i,
  input  logic [AW-1:0]                                cut_i,
  input  logic                                         road_valid_i,
  output logic                                         road_ready_o,
  input  logic [N_LAYERS*MAX_HITS*CW-1:0]              road_hits_i,
  input  logic [N_LAYERS*$clog2(MAX_HITS+1)-1:0]       road_cnt_i,
  output logic                                         cand_valid_o,
  output logic [N_PAR*AW-1:0]                          cand_par_o,
  output logic [AW-1:0]                                cand_chi_o,
  output logic [N_LAYERS*$clog2(MAX_HITS>1?MAX_HITS:2)-1:0] cand_hit_o
);
  localparam int N_ROWS = N_PAR + N_CON;
  localparam int N_COLS = N_LAYERS + 1;
  localparam int N_SETS = N_LAYERS + 1;
  localparam int SW     = $clog2(N_SETS);
  localparam int RW     = $clog2(N_ROWS);
  localparam int CLW    = $clog2(N_COLS);
  localparam int CNTW   = $clog2(MAX_HITS + 1);
  localparam int IDXW   = $clog2(MAX_HITS > 1 ? MAX_HITS : 2);

  logic                                   comb_valid;
  logic [N_LAYERS-1:0][CW-1:0]            comb_x;
  logic [N_LAYERS-1:0][IDXW-1:0]          comb_idx, dot_idx, out_idx;
  logic [SW-1:0]                          comb_set;
  logic [N_ROWS-1:0][N_COLS-1:0][KW-1:0]  coef;
  logic                                   dot_valid;
  logic [N_ROWS-1:0][AW-1:0]              dot_row;
  logic [N_PAR-1:0][AW-1:0]               out_par;

  fit_coef_store #(.N_LAYERS(N_LAYERS), .N_ROWS(N_ROWS), .KW(KW), .N_SETS(N_SETS),
                   .N_COLS(N_COLS), .SW(SW), .RW(RW), .CLW(CLW)) u_coef (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(coef_we_i), .wset_i(coef_set_i),
    .wrow_i(coef_row_i), .wcol_i(coef_col_i), .wdata_i(coef_data_i),
    .rset_i(comb_set), .rcoef_o(coef));

  fit_comb_seq #(.N_LAYERS(N_LAYERS), .MAX_HITS(MAX_HITS), .CW(CW), .CNTW(CNTW),
                 .IDXW(IDXW), .SW(SW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .road_valid_i(road_valid_i),
    .road_ready_o(road_ready_o), .road_hits_i(road_hits_i), .road_cnt_i(road_cnt_i),
    .comb_valid_o(comb_valid), .comb_x_o(comb_x), .comb_idx_o(comb_idx),
    .comb_set_o(comb_set));

  fit_dot_stage #(.N_LAYERS(N_LAYERS), .N_ROWS(N_ROWS), .CW(CW), .KW(KW), .AW(AW),
                  .IDXW(IDXW), .N_COLS(N_COLS)) u_dot (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(comb_valid), .x_i(comb_x),
    .idx_i(comb_idx), .coef_i(coef), .valid_o(dot_valid), .row_o(dot_row),
    .idx_o(dot_idx));

  fit_quality #(.N_PAR(N_PAR), .N_CON(N_CON), .AW(AW), .N_LAYERS(N_LAYERS),
                .IDXW(IDXW), .N_ROWS(N_ROWS)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(dot_valid), .row_i(dot_row),
    .idx_i(dot_idx), .cut_i(cut_i), .cand_valid_o(cand_valid_o),
    .cand_par_o(out_par), .cand_chi_o(cand_chi_o), .cand_idx_o(out_idx));

  assign cand_par_o = out_par;
  assign cand_hit_o = out_idx;

  // R3
  pipe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> $past(comb_valid, 2));
  // R1
  no_cand_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (road_ready_o && $past(road_ready_o) && $past(road_ready_o, 2)) |-> !cand_valid_o);
endmodule

// File: tb/road_track_fitter_test.sv
module road_track_fitter_test;
  localparam int AW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         coef_we = 1'b0;
  logic [2:0]   coef_set = '0;
  logic [1:0]   coef_row = '0;
  logic [2:0]   coef_col = '0;
  logic [15:0]  coef_data = '0;
  logic [39:0]  cut = '0;
  logic         road_valid = 1'b0;
  logic         road_ready;
  logic [255:0] road_hits = '0;
  logic [11:0]  road_cnt = '0;
  logic         cand_valid;
  logic [79:0]  cand_par;
  logic [39:0]  cand_chi;
  logic [7:0]   cand_hit;

  road_track_fitter uut (
    .clk_i(clk), .rst_ni(rst_n), .coef_we_i(coef_we), .coef_set_i(coef_set),
    .coef_row_i(coef_row), .coef_col_i(coef_col), .coef_data_i(coef_data),
    .cut_i(cut), .road_valid_i(road_valid), .road_ready_o(road_ready),
    .road_hits_i(road_hits), .road_cnt_i(road_cnt), .cand_valid_o(cand_valid),
    .cand_par_o(cand_par), .cand_chi_o(cand_chi), .cand_hit_o(cand_hit));

  int checks = 0;
  int errs = 0;
  int cm[5][4][5];
  int rh[4][4];
  int rc[4];

  longint     ep0[$], ep1[$];
  logic [39:0] ech[$];
  int         eix[$];
  logic [39:0] op0[$], op1[$], och[$];
  int         oix[$];

  always @(negedge clk) begin
    if (cand_valid) begin
      op0.push_back(cand_par[39:0]);
      op1.push_back(cand_par[79:40]);
      och.push_back(cand_chi);
      oix.push_back(int'(cand_hit));
    end
  end

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic longint t40(input longint v);
    logic [39:0] w;
    w = v[39:0];
    return longint'($signed(w));
  endfunction

  task automatic wr_coef(input int s, input int r, input int c, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_set = 3'(s); coef_row = 2'(r); coef_col = 3'(c);
    coef_data = 16'(v);
    cm[s][r][c] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // expected stream for the road held in rh/rc; returns combination count
  function automatic int predict();
    int lim[4];
    bit miss[4];
    int n_empty, set, total;
    n_empty = 0; set = 4; total = 1;
    for (int l = 0; l < 4; l++) begin
      int c;
      c = (rc[l] > 4) ? 4 : rc[l];
      miss[l] = (c == 0);
      lim[l]  = miss[l] ? 1 : c;
      if (miss[l]) begin n_empty++; set = l; end
      total *= lim[l];
    end
    if (n_empty > 1) return 0;
    for (int k = 0; k < total; k++) begin
      int ix[4];
      int tmp;
      longint par[4];
      logic signed [127:0] sq, v;
      logic [39:0] chi;
      int pk;
      tmp = k;
      for (int l = 3; l >= 0; l--) begin ix[l] = tmp % lim[l]; tmp = tmp / lim[l]; end
      for (int r = 0; r < 4; r++) begin
        par[r] = longint'(cm[set][r][4]);
        for (int l = 0; l < 4; l++)
          par[r] += longint'(cm[set][r][l]) * longint'(miss[l] ? 0 : rh[l][ix[l]]);
        par[r] = t40(par[r]);
      end
      sq = '0;
      for (int r = 2; r < 4; r++) begin v = par[r]; sq = sq + v * v; end
      chi = (sq > 128'hFF_FFFF_FFFF) ? 40'hFF_FFFF_FFFF : sq[39:0];
      pk = 0;
      for (int l = 0; l < 4; l++) pk |= ix[l] << (2 * l);
      if (chi <= cut) begin
        ep0.push_back(par[0]); ep1.push_back(par[1]);
        ech.push_back(chi); eix.push_back(pk);
      end
    end
    return total;
  endfunction

  task automatic run_road(input string req);
    int exp_busy, busy;
    for (int l = 0; l < 4; l++) begin
      road_cnt[3*l +: 3] = 3'(rc[l]);
      for (int h = 0; h < 4; h++) road_hits[(4*l+h)*16 +: 16] = 16'(rh[l][h]);
    end
    exp_busy = predict();
    @(negedge clk);
    chk(road_ready === 1'b1, "R1", $sformatf("ready before road act=%b exp=1", road_ready));
    road_valid = 1'b1;
    @(negedge clk);
    road_valid = 1'b0;
    busy = 0;
    while (road_ready !== 1'b1 && busy < 5000) begin busy++; @(negedge clk); end
    chk(busy == exp_busy, $sformatf("R1 %s", req),
        $sformatf("busy cycles act=%0d exp=%0d", busy, exp_busy));
    repeat (3) @(negedge clk);
    chk(op0.size() == ep0.size(), $sformatf("R5 %s", req),
        $sformatf("candidate count act=%0d exp=%0d", op0.size(), ep0.size()));
    for (int i = 0; i < ep0.size() && i < op0.size(); i++) begin
      chk(longint'($signed(op0[i])) == ep0[i] && longint'($signed(op1[i])) == ep1[i],
          $sformatf("R3 %s", req), $sformatf("cand %0d par act=%0d,%0d exp=%0d,%0d", i,
          longint'($signed(op0[i])), longint'($signed(op1[i])), ep0[i], ep1[i]));
      chk(och[i] == ech[i], $sformatf("R4 %s", req),
          $sformatf("cand %0d chi act=%0h exp=%0h", i, och[i], ech[i]));
      chk(oix[i] == eix[i], $sformatf("R2 %s", req),
          $sformatf("cand %0d hit idx act=%0h exp=%0h", i, oix[i], eix[i]));
    end
    ep0.delete(); ep1.delete(); ech.delete(); eix.delete();
    op0.delete(); op1.delete(); och.delete(); oix.delete();
  endtask

  task automatic rand_hits(input int span);
    for (int l = 0; l < 4; l++)
      for (int h = 0; h < 4; h++) rh[l][h] = int'($urandom_range(2 * span)) - span;
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(road_ready === 1'b1, "R1", $sformatf("reset ready act=%b exp=1", road_ready));
    chk(cand_valid === 1'b0, "R1", $sformatf("reset cand_valid act=%b exp=0", cand_valid));
    rst_n = 1'b1;

    // R9 load every set, row and column
    for (int s = 0; s < 5; s++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 5; c++)
          wr_coef(s, r, c, (c == 4) ? int'($urandom_range(2000)) - 1000
                                    : int'($urandom_range(120)) - 60);

    // R2 R3 full road, all pass
    cut = '1;
    rand_hits(2000);
    rc = '{4, 4, 4, 4};
    run_road("full");

    rc = '{2, 3, 1, 2};
    cut = 40'(64'($urandom) << 6);
    run_road("mixed");

    // R6 each layer empty in turn
    for (int m = 0; m < 4; m++) begin
      rand_hits(2000);
      rc = '{3, 2, 2, 3};
      rc[m] = 0;
      cut = '1;
      run_road("R6 empty layer");
    end

    // R7 two empty layers
    rc = '{0, 3, 0, 2};
    run_road("R7 two empty");

    // R8 clamped counts
    rc = '{7, 1, 5, 2};
    run_road("R8 clamp");

    // R5 zero cut
    cut = '0;
    rc = '{2, 2, 2, 2};
    run_road("R5 zero cut");

    // R4 saturation
    for (int c = 0; c < 4; c++) wr_coef(4, 2, c, 32767);
    wr_coef(4, 2, 4, 0);
    for (int l = 0; l < 4; l++) for (int h = 0; h < 4; h++) rh[l][h] = 32767;
    rc = '{1, 1, 1, 2};
    cut = '1;
    run_road("R4 saturate");
    for (int c = 0; c < 5; c++) wr_coef(4, 2, c, int'($urandom_range(120)) - 60);

    // random roads
    for (int n = 0; n < 25; n++) begin
      rand_hits(2000);
      for (int l = 0; l < 4; l++)
        rc[l] = ($urandom_range(9) == 0) ? 0 :
                ($urandom_range(15) == 0) ? int'($urandom_range(7, 5)) :
                int'($urandom_range(4, 1));
      cut = ($urandom_range(3) == 0) ? '1 : 40'(64'($urandom) << 6);
      run_road("random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule